// File: doc/BRIEF.md
# Audio FSK Receive Demodulator (1200 baud)

This block turns a stream of signed 8-bit audio samples, one sample per 9600 Hz strobe, into data bits at 1200 baud, eight samples per bit. A delay-and-multiply discriminator correlates each sample with the sample taken half a bit earlier. A first-order recursive low-pass filter smooths the product, and a sign slicer turns the filter output into a stream of sampled bits.

A digital phase-locked loop moves one step toward every slicer transition and fires once per bit period. At that point it takes a 2-of-3 majority over the newest sampled bits. The decided bits are then NRZI-decoded and presented with a one-clock valid strobe. Frame parsing, the converter and run-time filter selection sit outside the block.

Top module: `afsk_rx_demod`

## Requirements
- R1: Without slicer transitions, the phase counter grows by 8 on every accepted sample and wraps at 64. After reset with a silent input, a bit is therefore decided on the 8th accepted sample and on every 8th one after it.
- R2: Each accepted sample is multiplied, as a signed value, by the sample accepted 4 samples earlier. The 16-bit product is shifted right arithmetically by 2 to give the filter input x[n].
- R3: Reset fills the 4-sample delay line with zeros, so the first four products after reset are zero whatever the input.
- R4: The filter computes y[n] = x[n] + x[n-1] + (y[n-1]>>>1) + (y[n-1]>>>3) + (y[n-1]>>>5) in signed 16-bit arithmetic that wraps.
- R5: The slicer shifts a 1 into the sampled-bit history when y[n] is strictly greater than zero, and a 0 otherwise.
- R6: When the two newest sampled bits differ, the phase first moves by one step: +1 if it is below 32, and -1 otherwise. The advance of 8 is applied after that.
- R7: When the phase reaches 64 or more, it is reduced by 64 and the decided bit is 1 exactly when at least two of the three newest sampled bits are 1.
- R8: The output bit is 1 when the new decided bit equals the previous decided bit, and 0 when they differ. The previous decided bit is 0 after reset.
- R9: bit_valid rises for exactly one clock, in the cycle after the sample that completed the bit. Cycles without smp_valid leave all state unchanged and never raise bit_valid.
- R10: A synchronous reset clears the phase, the sample and decision histories, the filter state and the delay line, and holds bit_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Signed audio sample |
| bit_valid | output | 1 | One-clock strobe for a recovered bit |
| bit_data | output | 1 | NRZI-decoded data bit |

## Verification
Two things can land on the same sample: a slicer transition that nudges the phase, and the phase crossing 64, which triggers a decision. In that case the nudge must be applied before the wrap test. Otherwise the bit can be decided one sample early or late. Long tone streams, full value ramps and random sample sequences, with idle gaps between samples, move the phase through every offset around the wrap. For each accepted sample, an arithmetic reference in the bench states whether a bit falls due and what its value is.

// File: rtl/afsk_rx_demod.sv
module afsk_rx_demod #(
  parameter int SMP_W = 8,
  parameter int ACC_W = 16,
  parameter int SPB   = 8,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             bit_valid,
  output logic             bit_data
);
  localparam int DLY   = SPB / 2;
  localparam int PMAX  = SPB * STEP;
  localparam int PHALF = PMAX / 2;
  localparam int PH_W  = $clog2(PMAX + STEP + 2);

  logic signed [SMP_W-1:0] dly_q [DLY];
  logic signed [ACC_W-1:0] x_q, y_q, prod, x_n, y_n;
  logic [2:0]              hist_q, hist_n;
  logic [PH_W-1:0]         ph_q, ph_adj, ph_sum;
  logic                    dec_q, edge_n, decide, vote;

  assign prod   = ACC_W'(dly_q[DLY-1]) * ACC_W'($signed(smp_data));
  assign x_n    = prod >>> 2;
  assign y_n    = x_q + x_n + (y_q >>> 1) + (y_q >>> 3) + (y_q >>> 5);
  assign hist_n = {hist_q[1:0], (y_n > 0)};
  assign edge_n = hist_n[0] ^ hist_n[1];
  assign vote   = (hist_n[0] & hist_n[1]) | (hist_n[0] & hist_n[2]) | (hist_n[1] & hist_n[2]);

  always_comb begin
    ph_adj = ph_q;
    if (edge_n) ph_adj = (ph_q < PH_W'(PHALF)) ? ph_q + 1'b1 : ph_q - 1'b1;
    ph_sum = ph_adj + PH_W'(STEP);
  end

  assign decide = ph_sum >= PH_W'(PMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DLY; i++) dly_q[i] <= '0;
      x_q       <= '0;
      y_q       <= '0;
      hist_q    <= '0;
      ph_q      <= '0;
      dec_q     <= 1'b0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (smp_valid) begin
        dly_q[0] <= $signed(smp_data);
        for (int i = 1; i < DLY; i++) dly_q[i] <= dly_q[i-1];
        x_q    <= x_n;
        y_q    <= y_n;
        hist_q <= hist_n;
        if (decide) begin
          ph_q      <= ph_sum - PH_W'(PMAX);
          dec_q     <= vote;
          bit_valid <= 1'b1;
          bit_data  <= ~(vote ^ dec_q);
        end else begin
          ph_q <= ph_sum;
        end
      end
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst) ph_q < PH_W'(PMAX)); // R1
  AST_ONE_CLK_PULSE: assert property (@(posedge clk) disable iff (rst) bit_valid |=> !bit_valid); // R9
  AST_PULSE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst) bit_valid |-> $past(smp_valid)); // R9
  AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (rst) !smp_valid |=> $stable(ph_q) && $stable(y_q)); // R9
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    smp_valid && !bit_valid |=> bit_valid || ((ph_q - $past(ph_q)) >= PH_W'(STEP-1) && (ph_q - $past(ph_q)) <= PH_W'(STEP+1))); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> ph_q == '0 && !bit_valid && y_q == '0); // R10
endmodule

// File: tb/test_afsk_rx_demod.sv
module test_afsk_rx_demod;
  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic bit_valid, bit_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  afsk_rx_demod i_afsk_rx_demod (.clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_data(smp_data), .bit_valid(bit_valid), .bit_data(bit_data));

  logic signed [7:0]  m_dly [4];
  logic signed [15:0] m_x, m_y;
  logic [2:0] m_h;
  int m_ph;
  logic m_dec;
  int n_valid;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_dly[i] = '0;
    m_x = '0; m_y = '0; m_h = '0; m_ph = 0; m_dec = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(bit_valid == 1'b0, "R10 valid low in reset", bit_valid, 0);
    rst = 1'b0;
    model_reset();
    n_valid = 0;
  endtask

  task automatic send(input logic signed [7:0] s, input int gap);
    int p; logic signed [15:0] t, xn, yn; logic [2:0] h; bit ev, eb, vt;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = s;
    p = int'(m_dly[3]) * int'(s);
    t = 16'(p); xn = t >>> 2;
    yn = m_x + xn + (m_y >>> 1) + (m_y >>> 3) + (m_y >>> 5);
    h = {m_h[1:0], (yn > 0)};
    if (h[0] ^ h[1]) m_ph = (m_ph < 32) ? m_ph + 1 : m_ph - 1;
    m_ph += 8;
    ev = 1'b0; eb = 1'b0;
    if (m_ph >= 64) begin
      m_ph -= 64;
      vt = (int'(h[0]) + int'(h[1]) + int'(h[2])) >= 2;
      ev = 1'b1; eb = (vt == m_dec); m_dec = vt;
    end
    m_x = xn; m_y = yn; m_h = h;
    m_dly[3] = m_dly[2]; m_dly[2] = m_dly[1]; m_dly[1] = m_dly[0]; m_dly[0] = s;
    @(negedge clk);
    smp_valid = 1'b0;
    check(bit_valid == ev, "R2 R4 R5 R6 R7 strobe", bit_valid, ev);
    if (ev) begin
      n_valid++;
      check(bit_data == eb, "R8 R7 data", bit_data, eb);
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(bit_valid == 1'b0, "R9 idle no strobe", bit_valid, 0);
    end
  endtask

  task automatic tone_stream(input int nbits, input int seed_bits, input int gap);
    real ph, step; bit tone_space;
    int v;
    ph = 0.0; tone_space = 1'b0; v = seed_bits;
    for (int b = 0; b < nbits; b++) begin
      v = v * 1103515245 + 12345;
      if (v[16] == 1'b0) tone_space = ~tone_space;
      step = 2.0 * 3.14159265 * (tone_space ? 2200.0 : 1200.0) / 9600.0;
      for (int k = 0; k < 8; k++) begin
        ph += step;
        send(8'($rtoi(110.0 * $sin(ph))), gap);
      end
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    do_reset();
    // R1: silent input, strobes on samples 8 and 16, output bit 1
    for (int i = 1; i <= 16; i++) begin
      send(8'sd0, 0);
      if (i == 7)  check(n_valid == 0, "R1 no strobe before 8th sample", n_valid, 0);
      if (i == 8)  check(n_valid == 1, "R1 strobe on 8th sample", n_valid, 1);
      if (i == 15) check(n_valid == 1, "R1 period of 8", n_valid, 1);
    end
    check(n_valid == 2, "R1 two strobes in 16 samples", n_valid, 2);

    // R3: large samples right after reset meet zeros in the delay line
    do_reset();
    for (int i = 0; i < 4; i++) send(8'sd127, 1);
    for (int i = 0; i < 4; i++) send(-8'sd128, 0);
    for (int i = 0; i < 40; i++) send((i % 3 == 0) ? 8'sd127 : -8'sd100, 0);

    // full ramp of sample values, with and without idle gaps
    do_reset();
    for (int i = -128; i < 128; i++) send(8'(i), i & 1);
    for (int i = 127; i >= -128; i--) send(8'(i * 37), 0);

    // tone streams
    do_reset();
    tone_stream(120, 7, 0);
    tone_stream(60, 99, 2);

    // R10: reset in mid stream, then restart timing
    do_reset();
    for (int i = 1; i <= 8; i++) send(8'sd0, 0);
    check(n_valid == 1, "R10 R1 timing after mid-stream reset", n_valid, 1);
    tone_stream(80, 3, 0);

    // random samples
    for (int i = 0; i < 3000; i++) send(8'($urandom), ($urandom % 4 == 0) ? 1 : 0);

    finish_up();
  end
endmodule